// File: doc/BRIEF.md
# Decimal Point Scaling Unit

This block shifts the decimal point of a measured value by a signed number of places, so that a frequency or count that may be very large or very small fits one 16-bit result word. A negative position divides the measurement by a power of ten, and a positive position multiplies it by a power of ten. The division drops any remainder. If a setting falls outside the legal window, the block applies no scaling and raises an error flag.

A single start strobe captures the measurement and the position. The unit then applies one factor of ten per clock cycle. When the result is ready, a valid flag pulses for one cycle. The result and its flags stay on the outputs until the next computation finishes. A result that does not fit the output word is clamped to the largest code, and an overflow flag is raised.

Top module: `dec_scale`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `result_o`, `valid_o`, `err_o` and `ovf_o` are all zero until the first computation finishes.
- R2: `pos_i` is a 4-bit two's-complement value. A legal negative position -n (-4..-1) yields `value_i` divided by 10^n, truncated toward zero. Position 0 yields `value_i` unchanged.
- R3: A legal positive position +n (+1..+2) yields `value_i` multiplied by 10^n.
- R4: A position below -4 or above +2 is treated as 0, and `err_o` is 1 alongside that result. For a legal position, `err_o` is 0.
- R5: When the scaled value exceeds 65535, `result_o` is 65535 and `ovf_o` is 1. Otherwise `ovf_o` is 0.
- R6: `valid_o` is high for exactly one cycle per accepted start. It rises |n|+1 cycles after the clock edge that samples `start_i`, where n is the effective position.
- R7: A `start_i` that arrives while a computation is in progress has no effect. It does not change the running result and produces no extra `valid_o` pulse.
- R8: `result_o`, `err_o` and `ovf_o` keep their values from one `valid_o` pulse until the next, whatever `value_i` and `pos_i` do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin scaling (ignored while busy) |
| value_i | input | 32 | Unsigned measurement |
| pos_i | input | 4 | Signed decimal position, two's complement |
| result_o | output | 16 | Scaled, saturated result |
| valid_o | output | 1 | One-cycle pulse when the result is updated |
| err_o | output | 1 | Position was out of range; no scaling applied |
| ovf_o | output | 1 | Result was clamped to 65535 |

## Verification
The embedded assertions check, on every cycle, four properties of the block's timing and encoding:
- `valid_o` is a single-cycle pulse.
- The outputs cannot move while the unit is idle.
- The step counter only ever counts down while busy, so a late strobe cannot reload it.
- An overflow always comes with the clamped code, and an error always comes with a zero step count.

Only the bench scenarios can show that the arithmetic is correct for each legal position and that the latency matches the position magnitude. The same holds for the fall-back of illegal positions, for a strobe arriving mid-run really being ignored, and for a reset during a run cancelling it cleanly.

// File: rtl/dec_scale_pkg.sv
`timescale 1ns/1ps
package dec_scale_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} state_e;
endpackage

// File: rtl/dec_pos_check.sv
`timescale 1ns/1ps
module dec_pos_check #(
  parameter int POS_W   = 4,
  parameter int MIN_POS = -4,
  parameter int MAX_POS = 2,
  parameter int CNT_W   = 3
) (
  input  logic signed [POS_W-1:0] pos_i,
  output logic                    err_o,
  output logic                    mul_o,
  output logic [CNT_W-1:0]        steps_o
);
  localparam int MAX_MAG = (-MIN_POS > MAX_POS) ? -MIN_POS : MAX_POS;

  logic signed [POS_W:0] pos_ext;
  logic signed [POS_W:0] pos_neg;

  always_comb begin
    pos_ext = {pos_i[POS_W-1], pos_i};
    pos_neg = -pos_ext;
    err_o   = 1'b0;
    mul_o   = 1'b0;
    steps_o = '0;
    if ((int'(pos_i) < MIN_POS) || (int'(pos_i) > MAX_POS)) begin
      err_o = 1'b1;
    end else if (pos_i < 0) begin
      steps_o = pos_neg[CNT_W-1:0];
    end else begin
      mul_o   = 1'b1;
      steps_o = pos_ext[CNT_W-1:0];
    end
  end

  // R4: an illegal position never schedules a scaling step
  always_comb begin
    if (err_o) a_r4_fallback_zero: assert (steps_o == '0);
    a_r2_steps_bound: assert (int'(steps_o) <= MAX_MAG);
  end
endmodule

// File: rtl/dec_step.sv
`timescale 1ns/1ps
module dec_step #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             mul_i,
  output logic [ACC_W-1:0] acc_o
);
  always_comb begin
    if (mul_i) acc_o = (acc_i << 3) + (acc_i << 1);  // x*10 by shift-and-add
    else       acc_o = acc_i / ACC_W'(10);           // one truncating decade
  end

  // R2: a divide step never grows the value
  always_comb begin
    if (!mul_i) a_r2_div_shrinks: assert (acc_o <= acc_i);
  end
endmodule

// File: rtl/dec_sat.sv
`timescale 1ns/1ps
module dec_sat #(
  parameter int ACC_W = 40,
  parameter int OUT_W = 16
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] res_o,
  output logic             ovf_o
);
  always_comb begin
    ovf_o = |acc_i[ACC_W-1:OUT_W];
    res_o = ovf_o ? {OUT_W{1'b1}} : acc_i[OUT_W-1:0];
  end
endmodule

// File: rtl/dec_scale.sv
`timescale 1ns/1ps
module dec_scale
  import dec_scale_pkg::*;
#(
  parameter int IN_W    = 32,
  parameter int OUT_W   = 16,
  parameter int POS_W   = 4,
  parameter int MIN_POS = -4,
  parameter int MAX_POS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [IN_W-1:0]         value_i,
  input  logic signed [POS_W-1:0] pos_i,
  output logic [OUT_W-1:0]        result_o,
  output logic                    valid_o,
  output logic                    err_o,
  output logic                    ovf_o
);
  localparam int MAX_MAG = (-MIN_POS > MAX_POS) ? -MIN_POS : MAX_POS;
  localparam int CNT_W   = $clog2(MAX_MAG + 1);
  localparam int ACC_W   = IN_W + 4 * MAX_POS;  // 10 < 2^4 per multiply step

  state_e           state_q;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [CNT_W-1:0] steps_q, chk_steps;
  logic             mul_q, err_q, chk_err, chk_mul;
  logic [OUT_W-1:0] sat_res;
  logic             sat_ovf;

  dec_pos_check #(.POS_W(POS_W), .MIN_POS(MIN_POS), .MAX_POS(MAX_POS), .CNT_W(CNT_W)) u_chk (
    .pos_i(pos_i), .err_o(chk_err), .mul_o(chk_mul), .steps_o(chk_steps)
  );

  dec_step #(.ACC_W(ACC_W)) u_step (
    .acc_i(acc_q), .mul_i(mul_q), .acc_o(acc_nxt)
  );

  dec_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_sat (
    .acc_i(acc_q), .res_o(sat_res), .ovf_o(sat_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      acc_q    <= '0;
      steps_q  <= '0;
      mul_q    <= 1'b0;
      err_q    <= 1'b0;
      result_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            acc_q   <= ACC_W'(value_i);
            steps_q <= chk_steps;
            mul_q   <= chk_mul;
            err_q   <= chk_err;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (steps_q != '0) begin
            acc_q   <= acc_nxt;
            steps_q <= steps_q - 1'b1;
          end else begin
            result_o <= sat_res;
            ovf_o    <= sat_ovf;
            err_o    <= err_q;
            valid_o  <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> ($stable(result_o) && $stable(err_o) && $stable(ovf_o)));

  a_r7_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && steps_q != '0) |=> (steps_q == CNT_W'($past(steps_q) - 1'b1)));

  a_r5_sat_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o == {OUT_W{1'b1}}));
endmodule

// File: tb/dec_scale_bench.sv
`timescale 1ns/1ps
module dec_scale_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] value_i = '0;
  logic signed [3:0] pos_i = '0;
  logic [15:0] result_o;
  logic        valid_o, err_o, ovf_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dec_scale u_dec_scale (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .value_i(value_i), .pos_i(pos_i),
    .result_o(result_o), .valid_o(valid_o), .err_o(err_o), .ovf_o(ovf_o)
  );

  // {value[53:22], pos[21:18], result[17:2], err[1], ovf[0]}
  localparam int NV = 14;
  localparam logic [53:0] VEC [NV] = '{
    {32'd12345,      4'h0, 16'd12345, 1'b0, 1'b0},
    {32'd12345,      4'hE, 16'd123,   1'b0, 1'b0},
    {32'd99999,      4'hF, 16'd9999,  1'b0, 1'b0},
    {32'd4000000000, 4'hC, 16'd65535, 1'b0, 1'b1},
    {32'd6553,       4'h1, 16'd65530, 1'b0, 1'b0},
    {32'd6554,       4'h1, 16'd65535, 1'b0, 1'b1},
    {32'd655,        4'h2, 16'd65500, 1'b0, 1'b0},
    {32'd500,        4'h3, 16'd500,   1'b1, 1'b0},
    {32'd7,          4'hB, 16'd7,     1'b1, 1'b0},
    {32'd9,          4'hF, 16'd0,     1'b0, 1'b0},
    {32'd65535,      4'h0, 16'd65535, 1'b0, 1'b0},
    {32'd65536,      4'h0, 16'd65535, 1'b0, 1'b1},
    {32'hFFFFFFFF,   4'h2, 16'd65535, 1'b0, 1'b1},
    {32'd99999,      4'hC, 16'd9,     1'b0, 1'b0}
  };

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(logic [31:0] val, logic signed [3:0] pos, logic [15:0] er,
                         bit ee, bit eo, string tag);
    int lat;
    int steps;
    steps = (pos < -4 || pos > 2) ? 0 : (pos < 0 ? -int'(pos) : int'(pos));
    value_i = val; pos_i = pos; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    lat = 1;
    while (!valid_o && lat < 50) begin @(posedge clk); #1; lat++; end
    check(lat == steps + 2, "R6 latency", lat, steps + 2);
    check(result_o == er, tag, result_o, er);
    check(err_o == ee, "R4 error flag", err_o, ee);
    check(ovf_o == eo, "R5 overflow flag", ovf_o, eo);
    @(posedge clk); #1;
    check(!valid_o, "R6 single pulse", valid_o, 0);
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic        fault;
    repeat (3) @(posedge clk);
    #1;
    check(result_o == 0 && !valid_o && !err_o && !ovf_o, "R1 reset outputs", result_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(result_o == 0 && !valid_o, "R1 after release", result_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic signed [3:0] p;
      string tag;
      p = VEC[i][21:18];
      if (VEC[i][1]) tag = "R4 fallback result";
      else if (VEC[i][0]) tag = "R5 saturated result";
      else if (p > 0) tag = "R3 multiply result";
      else tag = "R2 divide/pass result";
      run_one(VEC[i][53:22], p, VEC[i][17:2], VEC[i][1], VEC[i][0], tag);
    end

    // R8: outputs hold while inputs wander without a start
    run_one(32'd4321, 4'hF, 16'd432, 1'b0, 1'b0, "R2 divide result");
    held = result_o;
    fault = 1'b0;
    for (int k = 0; k < 6; k++) begin
      value_i = 32'd77 * k; pos_i = 4'(k);
      @(posedge clk); #1;
      if (result_o != held || err_o || ovf_o || valid_o) fault = 1'b1;
    end
    check(!fault, "R8 hold between results", result_o, held);

    // R7: a strobe while busy is ignored
    value_i = 32'd99999; pos_i = 4'hC; start_i = 1'b1;
    @(posedge clk); #1;
    value_i = 32'd5; pos_i = 4'h0;
    @(posedge clk); #1 start_i = 1'b0;
    fault = 1'b0;
    for (int k = 0; k < 20 && !valid_o; k++) begin @(posedge clk); #1; end
    check(valid_o && result_o == 16'd9, "R7 busy start ignored", result_o, 9);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      if (valid_o) fault = 1'b1;
    end
    check(!fault, "R7 no extra valid", fault, 0);

    // R1: reset in the middle of a run cancels it
    value_i = 32'd99999; pos_i = 4'hC; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    @(posedge clk); #1 rst_ni = 1'b0;
    #1;
    check(result_o == 0 && !err_o && !ovf_o && !valid_o, "R1 mid-run reset", result_o, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    fault = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      if (valid_o) fault = 1'b1;
    end
    check(!fault, "R1 no valid after reset", fault, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule